// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block is the interrupt front end of a small CPU. It gathers six request sources and delivers one decision per instruction-fetch boundary. The sources are a non-maskable level 0, an internal stack-fault request at level 1, and four active-low external pins at levels 2 to 5. The decision is a one-cycle take pulse, the level that won, and the address of the memory word that holds the service routine's start address. The core uses the take pulse to abort the fetch, push its program counter and load the new one from that address. Those steps happen outside this block.

Each maskable level keeps its request in a latch. A short pulse sets the latch, and the level's own enable bit holds it cleared. Only an explicit per-level clear strobe empties a latch. A master enable must be set before any latched request is honoured. The block drops the master enable when it takes an interrupt, and a return-from-interrupt strobe sets it again.

Level 0 has no latch enable and is never masked. It is decoded from the halt and continue lines. When halt goes low, the core stalls. If continue is pulled low before halt rises again, a level 0 request is recorded. If halt rises while continue is still high, the event was only a stall.

Top module: `irq_vector_unit`

## Requirements
- R1: When several requests are eligible at one fetch boundary, the lowest level number wins. Level 0 beats the stack request (level 1), which beats external pins 0..3 (levels 2..5).
- R2: The vector address is NMI_VEC (default 0) for level 0 and 2, 3, 4, 5, 6 for levels 1 to 5. A stack request taken while levels 3 and 5 are also pending still gives address 2.
- R3: An external pin is active low. Holding it low for a single clock is enough to latch the request after the two-stage synchronizer, with no need to hold it until acknowledge.
- R4: While a level's bit in `lvl_en` is 0, its latch is held empty. A request pulsed before the enable was dropped is therefore lost, and re-enabling the level does not bring it back.
- R5: With `master_en` at 0, no maskable request is taken. Writing `men_d` with `men_wr` sets or clears `master_en`.
- R6: Requests are acted on only in a cycle where `fetch_start` is 1. In the cycle that follows, `irq_take` is 1 for exactly one cycle, `cont_ack_n` is 0 for that same cycle, and `master_en` reads 0.
- R7: `rti` sets `master_en` but leaves the latches alone. A request that has not been cleared is therefore taken again at the next fetch boundary.
- R8: A strobe on a level's bit of `lvl_clr` empties that level's latch.
- R9: Halt low followed by continue low, both before halt returns high, records a level 0 request. Halt returning high while continue is still high records nothing. `stall` is 1 while the synchronized halt is low.
- R10: A recorded level 0 request is taken regardless of `master_en` and `lvl_en`. It is taken once only.
- R11: After reset, `master_en` is 0, `irq_take` is 0, `cont_ack_n` is 1, `stall` is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_req_n | input | N_EXT | External request pins, active low; bit i is level i+2 |
| stack_req | input | 1 | Internal stack full/empty request, level 1 |
| lvl_en | input | N_EXT+1 | Per-level enables; bit 0 is level 1 |
| lvl_clr | input | N_EXT+1 | Per-level latch clear strobes |
| men_wr | input | 1 | Write strobe for the master enable |
| men_d | input | 1 | Value written to the master enable |
| rti | input | 1 | Return-from-interrupt strobe |
| fetch_start | input | 1 | Instruction-fetch boundary |
| halt_n | input | 1 | Halt line, active low |
| cont_in | input | 1 | Continue line as driven externally |
| irq_take | output | 1 | Abort fetch and push the program counter |
| irq_level | output | LVL_W | Level that was taken |
| vec_addr | output | VEC_W | Address of the vector word |
| cont_ack_n | output | 1 | Low-going acknowledge pulse |
| master_en | output | 1 | Master enable flag |
| stall | output | 1 | Processor held by halt |

## Verification
A stack request pending together with levels 3 and 5 is the main case. A faulty arbiter would report address 0 or a lower-priority level there, instead of address 2 and level 1. The bench drops an enable over a request that is already latched and then re-enables it. A design whose enable only gates recognition would take a stale interrupt here. It also returns from an interrupt without clearing the latch, to show the level is taken again. A design that cleared latches on `rti` or on acceptance would go silent. The halt/continue orderings are driven both ways: a stall that also raised level 0, or a level 0 lost behind master enable, shows up directly on `irq_take`.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int VEC_W = 16,
  parameter int N_EXT = 4,
  parameter logic [VEC_W-1:0] NMI_VEC = '0,
  parameter int STK_VEC = 2,
  localparam int NLAT = N_EXT + 1,
  localparam int LVL_W = $clog2(NLAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_req_n,
  input  logic             stack_req,
  input  logic [NLAT-1:0]  lvl_en,
  input  logic [NLAT-1:0]  lvl_clr,
  input  logic             men_wr,
  input  logic             men_d,
  input  logic             rti,
  input  logic             fetch_start,
  input  logic             halt_n,
  input  logic             cont_in,
  output logic             irq_take,
  output logic [LVL_W-1:0] irq_level,
  output logic [VEC_W-1:0] vec_addr,
  output logic             cont_ack_n,
  output logic             master_en,
  output logic             stall
);

  logic [N_EXT-1:0] rq_a, rq_b;
  logic             hs_a, hs_b, h_prev, cs_a, cs_b;
  logic [NLAT-1:0]  lat;
  logic             armed, nmi_pend;
  logic             pick_ok;
  int               pick;
  logic             accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_a <= '0; rq_b <= '0;
      hs_a <= 1'b1; hs_b <= 1'b1; h_prev <= 1'b1;
      cs_a <= 1'b1; cs_b <= 1'b1;
    end else begin
      rq_a <= ~ext_req_n; rq_b <= rq_a;
      hs_a <= halt_n; hs_b <= hs_a; h_prev <= hs_b;
      cs_a <= cont_in; cs_b <= cs_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else        lat <= lvl_en & ~lvl_clr & (lat | {rq_b, stack_req});
  end

  always_comb begin
    pick_ok = 1'b0;
    pick    = 0;
    for (int i = NLAT - 1; i >= 0; i--)
      if (lat[i]) begin
        pick_ok = 1'b1;
        pick    = i;
      end
  end

  assign accept = fetch_start & (nmi_pend | (master_en & pick_ok));
  assign stall  = ~hs_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      if (hs_b)       armed <= 1'b0;
      else if (!cs_b) armed <= 1'b1;
      nmi_pend <= (hs_b & ~h_prev & armed) | (nmi_pend & ~accept);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take   <= 1'b0;
      cont_ack_n <= 1'b1;
      irq_level  <= '0;
      vec_addr   <= '0;
      master_en  <= 1'b0;
    end else begin
      irq_take   <= accept;
      cont_ack_n <= ~accept;
      if (accept) begin
        master_en <= 1'b0;
        if (nmi_pend) begin
          irq_level <= '0;
          vec_addr  <= NMI_VEC;
        end else begin
          irq_level <= LVL_W'(pick + 1);
          vec_addr  <= VEC_W'(STK_VEC + pick);
        end
      end else if (rti) begin
        master_en <= 1'b1;
      end else if (men_wr) begin
        master_en <= men_d;
      end
    end
  end

endmodule

module irq_vector_unit_chk #(
  parameter int VEC_W = 16,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_start,
  input logic             rti,
  input logic             irq_take,
  input logic [LVL_W-1:0] irq_level,
  input logic [VEC_W-1:0] vec_addr,
  input logic             cont_ack_n,
  input logic             master_en
);
  AST_TAKE_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n) irq_take |-> $past(fetch_start)); // R6
  AST_TAKE_DROPS_MEN: assert property (@(posedge clk) disable iff (!rst_n) irq_take |-> !master_en); // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !cont_ack_n |=> cont_ack_n); // R6
  AST_MASKED_NEEDS_MEN: assert property (@(posedge clk) disable iff (!rst_n) (irq_take && irq_level != 0) |-> $past(master_en)); // R5
  AST_STACK_VEC_TWO: assert property (@(posedge clk) disable iff (!rst_n) (irq_take && irq_level == 1) |-> vec_addr == 2); // R2
  AST_RTI_SETS_MEN: assert property (@(posedge clk) disable iff (!rst_n) rti |=> (master_en || irq_take)); // R7
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] ext_req_n = 4'hF;
  logic stack_req = 0;
  logic [4:0] lvl_en = 5'h1F;
  logic [4:0] lvl_clr = 0;
  logic men_wr = 0, men_d = 0, rti = 0, fetch_start = 0;
  logic halt_n = 1, cont_in = 1;
  logic irq_take, cont_ack_n, master_en, stall;
  logic [2:0] irq_level;
  logic [15:0] vec_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic s_take, s_ack, s_men;
  logic [2:0] s_lvl;
  logic [15:0] s_vec;

  always #2 clk = ~clk;

  irq_vector_unit u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fetch();
    fetch_start = 1;
    step(1);
    fetch_start = 0;
    s_take = irq_take; s_ack = cont_ack_n; s_men = master_en;
    s_lvl = irq_level; s_vec = vec_addr;
    step(1);
  endtask

  task automatic set_men(input logic v);
    men_wr = 1; men_d = v; step(1); men_wr = 0;
  endtask

  task automatic do_rti();
    rti = 1; step(1); rti = 0;
  endtask

  task automatic clr(input int lv);
    lvl_clr[lv-1] = 1; step(1); lvl_clr = 0;
  endtask

  task automatic pulse_ext(input int i);
    ext_req_n[i] = 0; step(1); ext_req_n[i] = 1; step(3);
  endtask

  task automatic t_reset();
    check("R11 master_en", master_en, 0);
    check("R11 take", irq_take, 0);
    check("R11 ack_n", cont_ack_n, 1);
    check("R11 stall", stall, 0);
    fetch();
    check("R11 nothing pending", s_take, 0);
  endtask

  task automatic t_mask_and_take();
    pulse_ext(0);
    fetch();
    check("R5 masked no take", s_take, 0);
    set_men(1);
    check("R5 men written", master_en, 1);
    step(3);
    check("R6 no take without fetch", irq_take, 0);
    fetch();
    check("R3 short pulse taken", s_take, 1);
    check("R3 level", s_lvl, 2);
    check("R2 vec level2", s_vec, 3);
    check("R6 ack low", s_ack, 0);
    check("R6 men cleared", s_men, 0);
    check("R6 take one cycle", irq_take, 0);
    check("R6 ack back high", cont_ack_n, 1);
    do_rti();
    check("R7 rti sets men", master_en, 1);
    fetch();
    check("R7 latch kept after rti", s_take, 1);
    check("R7 same level", s_lvl, 2);
    clr(2);
    do_rti();
    fetch();
    check("R8 cleared no take", s_take, 0);
  endtask

  task automatic t_priority();
    stack_req = 1; ext_req_n[1] = 0; ext_req_n[3] = 0;
    step(1);
    stack_req = 0; ext_req_n = 4'hF;
    step(3);
    fetch();
    check("R1 stack wins", s_lvl, 1);
    check("R2 stack vec is 2", s_vec, 2);
    clr(1); do_rti(); fetch();
    check("R1 level3 next", s_lvl, 3);
    check("R2 vec level3", s_vec, 4);
    clr(3); do_rti(); fetch();
    check("R1 level5 last", s_lvl, 5);
    check("R2 vec level5", s_vec, 6);
    clr(5); do_rti();
    fetch();
    check("R8 all cleared", s_take, 0);
  endtask

  task automatic t_enable_discard();
    pulse_ext(2);
    lvl_en[3] = 0; step(1); lvl_en[3] = 1; step(1);
    fetch();
    check("R4 discarded by enable", s_take, 0);
    lvl_en[3] = 0;
    pulse_ext(2);
    lvl_en[3] = 1; step(1);
    fetch();
    check("R4 held clear while disabled", s_take, 0);
    pulse_ext(2);
    fetch();
    check("R4 works when enabled", s_lvl, 4);
    check("R2 vec level4", s_vec, 5);
    clr(4); do_rti();
  endtask

  task automatic t_nmi();
    set_men(0);
    lvl_en = 0;
    halt_n = 0; step(3);
    check("R9 stall while halted", stall, 1);
    cont_in = 0; step(3);
    halt_n = 1; step(4);
    cont_in = 1; step(2);
    check("R9 stall released", stall, 0);
    fetch();
    check("R10 nmi taken unmasked", s_take, 1);
    check("R10 level0", s_lvl, 0);
    check("R2 nmi vec", s_vec, 0);
    check("R6 nmi ack", s_ack, 0);
    fetch();
    check("R10 taken once", s_take, 0);
    halt_n = 0; step(4);
    halt_n = 1; step(4);
    fetch();
    check("R9 plain stall no irq", s_take, 0);
    lvl_en = 5'h1F;
  endtask

  task automatic t_nmi_over_stack();
    stack_req = 1; step(1); stack_req = 0;
    set_men(1);
    halt_n = 0; step(3); cont_in = 0; step(3);
    halt_n = 1; step(4); cont_in = 1;
    fetch();
    check("R1 level0 over stack", s_lvl, 0);
    do_rti(); fetch();
    check("R1 stack after level0", s_lvl, 1);
    clr(1);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    t_reset();
    t_mask_and_take();
    t_priority();
    t_enable_discard();
    t_nmi();
    t_nmi_over_stack();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule